// File: doc/BRIEF.md
# Coalescing Store Buffer with Atomic Group Tracking

This block holds committed stores between the core and the first-level cache. Each entry covers one whole cacheline. A store whose line already has an open entry is merged into that entry, even when other stores to other lines arrived in between. Coalescing a non-adjacent store changes the order in which lines reach the cache. To keep that reordering invisible, the block tags every entry with an atomic group ID. Coalescing fuses every group from the matched one up to the newest into a single group. The write-out side is handed one group at a time, oldest first, so that it can perform the lines of a group as one indivisible unit.

A store with no open entry for its line takes a free entry and a fresh group ID. When neither a free entry nor an open match exists, the commit port stalls. When a group has started writing out, its remaining lines are closed to merging, so a partly written group never changes. A later store to such a line opens a new entry in a new group. Each accepted store also raises a write-permission prefetch request one cycle later. A same-core load can look up a line at any time. For each byte, it receives the youngest buffered value.

Top module: `coalescing_store_buffer`

## Requirements
- R1: After reset, group IDs are handed out from 0 upward. A store that allocates an entry gets the ID one above the newest live group, modulo ENTRIES.
- R2: A store that matches an open entry of its line is merged byte by byte: bytes whose mask bit is 1 overwrite the old bytes, no entry is allocated, and the line mask becomes the OR of both masks.
- R3: When a store merges into an entry of group g, every live group from g up to the newest, g included, is re-tagged with one ID. That ID is also the store's own fresh ID, and it is the lowest position in the merged span (g).
- R4: Interleaved coalescing pairs chain, so every group touched by overlapping pairs ends up in one group.
- R5: The drain port shows only lines of the oldest live group, with that group's ID. drain_last is 1 only on the group's final remaining line.
- R6: Each drain transfer carries the full line (address, byte mask, data) and frees its entry on the cycle drain_valid and drain_ready are both 1.
- R7: After the first line of the oldest group has been drained, its remaining lines are closed. A store to one of them allocates a new entry in a new group, and the closed line drains with its old data.
- R8: A load lookup returns a per-byte hit mask and the youngest buffered byte for each hit byte. Bytes that do not hit read as 0. Byte b is data bits [8b+7:8b].
- R9: One cycle after a store is accepted, pf_valid is 1 for one cycle with pf_line equal to that store's line.
- R10: st_ready is 0 only when every entry is valid and no open entry matches st_line.
- R11: When a group has fully drained, the next group drained carries the next ID modulo ENTRIES, so IDs are reused in a circle.
- R12: After reset, st_ready is 1, drain_valid and pf_valid are 0, and every load lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | A committed store is offered |
| st_ready | output | 1 | The store is accepted this cycle |
| st_line | input | LINE_AW | Cacheline address of the store |
| st_mask | input | LINE_BYTES | Byte enables of the store |
| st_data | input | 8*LINE_BYTES | Store data aligned within the line |
| pf_valid | output | 1 | Write-permission prefetch request |
| pf_line | output | LINE_AW | Line to prefetch permission for |
| ld_line | input | LINE_AW | Load lookup line address |
| ld_hit_mask | output | LINE_BYTES | Bytes found in the buffer |
| ld_data | output | 8*LINE_BYTES | Youngest buffered bytes, zero where missed |
| drain_valid | output | 1 | A line of the oldest group is presented |
| drain_ready | input | 1 | The write-out side takes the line |
| drain_line | output | LINE_AW | Address of the presented line |
| drain_mask | output | LINE_BYTES | Written bytes of the presented line |
| drain_data | output | 8*LINE_BYTES | Data of the presented line |
| drain_gid | output | log2(ENTRIES) | Atomic group ID of the presented line |
| drain_last | output | 1 | Final remaining line of its group |

## Verification
The assertions assume that ENTRIES is a power of two, so that modular group arithmetic wraps in the ID field itself. They also assume that the store inputs stay constant while they are sampled on a clock edge. The group-order properties assume that the write-out side may raise drain_ready only when it is willing to take whatever line is presented. The stimulus changes inputs only half a cycle away from the active edge. It raises drain_ready for single cycles, and it offers a store to a full buffer only as a probe that it withdraws before the next edge, so no stalled store is ever left pending.

// File: rtl/csb_pkg.sv
package csb_pkg;

  // What the commit port does with the offered store in the current cycle
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2
  } st_action_e;

endpackage

// File: rtl/csb_first.sv
// Lowest-index set bit finder
module csb_first #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/csb_lookup.sv
// Address comparators shared by the commit and load sides
module csb_lookup #(
  parameter int N   = 4,
  parameter int LAW = 8
) (
  input  logic [N-1:0]          ent_valid,
  input  logic [N-1:0]          ent_closed,
  input  logic [N-1:0][LAW-1:0] ent_line,
  input  logic [LAW-1:0]        st_line,
  input  logic [LAW-1:0]        ld_line,
  output logic [N-1:0]          st_hit_vec,
  output logic [N-1:0]          ld_open_vec,
  output logic [N-1:0]          ld_closed_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign st_hit_vec[i]    = ent_valid[i] && !ent_closed[i] && (ent_line[i] == st_line);
    assign ld_open_vec[i]   = ent_valid[i] && !ent_closed[i] && (ent_line[i] == ld_line);
    assign ld_closed_vec[i] = ent_valid[i] &&  ent_closed[i] && (ent_line[i] == ld_line);
  end
endmodule

// File: rtl/csb_forward.sv
// Per-byte youngest-value selection for load lookups: an open entry is
// always younger than a closed entry of the same line.
module csb_forward #(
  parameter int N  = 4,
  parameter int LB = 4,
  localparam int DW = LB * 8
) (
  input  logic [N-1:0]         open_vec,
  input  logic [N-1:0]         closed_vec,
  input  logic [N-1:0][LB-1:0] ent_mask,
  input  logic [N-1:0][DW-1:0] ent_data,
  output logic [LB-1:0]        hit_mask,
  output logic [DW-1:0]        hit_data
);
  for (genvar b = 0; b < LB; b++) begin : g_byte
    logic       young_hit, old_hit;
    logic [7:0] young_byte, old_byte;
    always_comb begin
      young_hit  = 1'b0;
      old_hit    = 1'b0;
      young_byte = '0;
      old_byte   = '0;
      for (int i = 0; i < N; i++) begin
        if (open_vec[i] && ent_mask[i][b]) begin
          young_hit  = 1'b1;
          young_byte = young_byte | ent_data[i][b*8 +: 8];
        end
        if (closed_vec[i] && ent_mask[i][b]) begin
          old_hit  = 1'b1;
          old_byte = old_byte | ent_data[i][b*8 +: 8];
        end
      end
    end
    assign hit_mask[b]        = young_hit | old_hit;
    assign hit_data[b*8 +: 8] = young_hit ? young_byte : old_byte;
  end
endmodule

// File: rtl/coalescing_store_buffer.sv
module coalescing_store_buffer
  import csb_pkg::*;
#(
  parameter int ENTRIES    = 4,
  parameter int LINE_AW    = 8,
  parameter int LINE_BYTES = 4,
  localparam int GID_W = $clog2(ENTRIES),
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int DW    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [LINE_AW-1:0]    st_line,
  input  logic [LINE_BYTES-1:0] st_mask,
  input  logic [DW-1:0]         st_data,
  output logic                  pf_valid,
  output logic [LINE_AW-1:0]    pf_line,
  input  logic [LINE_AW-1:0]    ld_line,
  output logic [LINE_BYTES-1:0] ld_hit_mask,
  output logic [DW-1:0]         ld_data,
  output logic                  drain_valid,
  input  logic                  drain_ready,
  output logic [LINE_AW-1:0]    drain_line,
  output logic [LINE_BYTES-1:0] drain_mask,
  output logic [DW-1:0]         drain_data,
  output logic [GID_W-1:0]      drain_gid,
  output logic                  drain_last
);

  // ---------------- arithmetic helpers ----------------
  // Position of a group in age order, counted from the oldest live group
  function automatic logic [GID_W-1:0] gid_age(input logic [GID_W-1:0] g,
                                               input logic [GID_W-1:0] oldest);
    return g - oldest;
  endfunction

  // Byte-wise overlay of newer data on older data
  function automatic logic [DW-1:0] overlay(input logic [DW-1:0] older,
                                            input logic [DW-1:0] newer,
                                            input logic [LINE_BYTES-1:0] be);
    logic [DW-1:0] r;
    for (int b = 0; b < LINE_BYTES; b++)
      r[b*8 +: 8] = be[b] ? newer[b*8 +: 8] : older[b*8 +: 8];
    return r;
  endfunction

  function automatic int unsigned pop_count(input logic [ENTRIES-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < ENTRIES; i++) n += int'(v[i]);
    return n;
  endfunction

  // ---------------- entry state ----------------
  logic [ENTRIES-1:0]                 ent_valid;
  logic [ENTRIES-1:0][LINE_AW-1:0]    ent_line;
  logic [ENTRIES-1:0][LINE_BYTES-1:0] ent_mask;
  logic [ENTRIES-1:0][DW-1:0]         ent_data;
  logic [ENTRIES-1:0][GID_W-1:0]      ent_gid;
  logic [GID_W-1:0]                   oldest_gid_q;   // group at the drain side
  logic [GID_W-1:0]                   newest_gid_q;   // most recently issued ID
  logic                               wr_open_q;      // oldest group partly drained
  logic                               pf_valid_q;
  logic [LINE_AW-1:0]                 pf_line_q;

  // ---------------- named internal events ----------------
  logic [ENTRIES-1:0] oldest_vec;
  logic [ENTRIES-1:0] ent_closed;
  logic [ENTRIES-1:0] st_hit_vec;
  logic [ENTRIES-1:0] ld_open_vec, ld_closed_vec;
  logic               st_hit, has_free, drain_fire, st_fire;
  logic [IDX_W-1:0]   hit_idx, free_idx, drain_idx;
  logic [GID_W-1:0]   merge_gid, fresh_gid;
  st_action_e         st_act;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_class
    assign oldest_vec[i] = ent_valid[i] && (ent_gid[i] == oldest_gid_q);
    assign ent_closed[i] = oldest_vec[i] && (wr_open_q || drain_fire);
  end

  csb_lookup #(.N(ENTRIES), .LAW(LINE_AW)) u_lookup (
    .ent_valid    (ent_valid),
    .ent_closed   (ent_closed),
    .ent_line     (ent_line),
    .st_line      (st_line),
    .ld_line      (ld_line),
    .st_hit_vec   (st_hit_vec),
    .ld_open_vec  (ld_open_vec),
    .ld_closed_vec(ld_closed_vec)
  );

  csb_first #(.N(ENTRIES)) u_hit_pick (
    .req(st_hit_vec), .found(st_hit), .idx(hit_idx)
  );

  csb_first #(.N(ENTRIES)) u_free_pick (
    .req(~ent_valid), .found(has_free), .idx(free_idx)
  );

  csb_first #(.N(ENTRIES)) u_drain_pick (
    .req(oldest_vec), .found(drain_valid), .idx(drain_idx)
  );

  csb_forward #(.N(ENTRIES), .LB(LINE_BYTES)) u_forward (
    .open_vec  (ld_open_vec),
    .closed_vec(ld_closed_vec),
    .ent_mask  (ent_mask),
    .ent_data  (ent_data),
    .hit_mask  (ld_hit_mask),
    .hit_data  (ld_data)
  );

  // ---------------- commit side ----------------
  assign st_ready  = st_hit || has_free;
  assign st_fire   = st_valid && st_ready;
  assign merge_gid = ent_gid[hit_idx];
  // A merge takes the lowest ID of the span it fuses, so live IDs stay contiguous
  assign fresh_gid = st_hit ? merge_gid : GID_W'(newest_gid_q + 1'b1);

  always_comb begin
    if (!st_fire)    st_act = ACT_IDLE;
    else if (st_hit) st_act = ACT_MERGE;
    else             st_act = ACT_ALLOC;
  end

  // ---------------- drain side ----------------
  assign drain_fire = drain_valid && drain_ready;
  assign drain_line = ent_line[drain_idx];
  assign drain_mask = ent_mask[drain_idx];
  assign drain_data = ent_data[drain_idx];
  assign drain_gid  = oldest_gid_q;
  assign drain_last = (pop_count(oldest_vec) == 1);

  assign pf_valid = pf_valid_q;
  assign pf_line  = pf_line_q;

  // ---------------- state update ----------------
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic freed, merged, alloc, retag;
    assign freed  = drain_fire && (drain_idx == IDX_W'(i));
    assign merged = (st_act == ACT_MERGE) && (hit_idx == IDX_W'(i));
    assign alloc  = (st_act == ACT_ALLOC) && (free_idx == IDX_W'(i));
    assign retag  = (st_act == ACT_MERGE) && ent_valid[i] &&
                    (gid_age(ent_gid[i], oldest_gid_q) >= gid_age(merge_gid, oldest_gid_q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_line[i]  <= '0;
        ent_mask[i]  <= '0;
        ent_data[i]  <= '0;
        ent_gid[i]   <= '0;
      end else begin
        if (freed) ent_valid[i] <= 1'b0;
        if (merged) begin
          ent_mask[i] <= ent_mask[i] | st_mask;
          ent_data[i] <= overlay(ent_data[i], st_data, st_mask);
        end
        if (retag) ent_gid[i] <= merge_gid;
        if (alloc) begin
          ent_valid[i] <= 1'b1;
          ent_line[i]  <= st_line;
          ent_mask[i]  <= st_mask;
          ent_data[i]  <= overlay('0, st_data, st_mask);
          ent_gid[i]   <= fresh_gid;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oldest_gid_q <= '0;
      newest_gid_q <= GID_W'(ENTRIES - 1);
      wr_open_q    <= 1'b0;
      pf_valid_q   <= 1'b0;
      pf_line_q    <= '0;
    end else begin
      if (drain_fire) begin
        wr_open_q <= !drain_last;
        if (drain_last) oldest_gid_q <= GID_W'(oldest_gid_q + 1'b1);
      end
      if (st_fire) newest_gid_q <= fresh_gid;
      pf_valid_q <= st_fire;
      if (st_fire) pf_line_q <= st_line;
    end
  end

endmodule

// File: rtl/csb_checker.sv
module csb_checker
  import csb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_AW = 8,
  localparam int GID_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_valid,
  input logic               st_ready,
  input logic [LINE_AW-1:0] st_line,
  input logic               pf_valid,
  input logic [LINE_AW-1:0] pf_line,
  input logic [ENTRIES-1:0] st_hit_vec,
  input logic [ENTRIES-1:0] ent_valid,
  input st_action_e         st_act,
  input logic               drain_valid,
  input logic               drain_ready,
  input logic [GID_W-1:0]   drain_gid,
  input logic               drain_last
);

  assert_prefetch_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> (pf_valid && pf_line == $past(st_line)));

  assert_stall_only_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> (&ent_valid));

  assert_single_merge_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_hit_vec));

  assert_merge_no_growth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_act == ACT_MERGE) |=> ($countones(ent_valid) <= $past($countones(ent_valid))));

  assert_alloc_has_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_act == ACT_ALLOC) |-> !(&ent_valid));

  assert_group_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !(drain_ready && drain_last)) |=>
      (drain_valid && drain_gid == $past(drain_gid)));

  assert_group_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && drain_ready && drain_last) |=>
      (!drain_valid || drain_gid == GID_W'($past(drain_gid) + 1'b1)));

endmodule

bind coalescing_store_buffer csb_checker #(.ENTRIES(ENTRIES), .LINE_AW(LINE_AW)) u_csb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .st_line    (st_line),
  .pf_valid   (pf_valid),
  .pf_line    (pf_line),
  .st_hit_vec (st_hit_vec),
  .ent_valid  (ent_valid),
  .st_act     (st_act),
  .drain_valid(drain_valid),
  .drain_ready(drain_ready),
  .drain_gid  (drain_gid),
  .drain_last (drain_last)
);

// File: tb/coalescing_store_buffer_bench.sv
module coalescing_store_buffer_bench;
  localparam int NE  = 4;
  localparam int LAW = 8;
  localparam int LB  = 4;
  localparam int DW  = LB * 8;
  localparam int GW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [LAW-1:0] st_line = '0;
  logic [LB-1:0] st_mask = '0;
  logic [DW-1:0] st_data = '0;
  logic          pf_valid;
  logic [LAW-1:0] pf_line;
  logic [LAW-1:0] ld_line = '0;
  logic [LB-1:0] ld_hit_mask;
  logic [DW-1:0] ld_data;
  logic          drain_valid;
  logic          drain_ready = 1'b0;
  logic [LAW-1:0] drain_line;
  logic [LB-1:0] drain_mask;
  logic [DW-1:0] drain_data;
  logic [GW-1:0] drain_gid;
  logic          drain_last;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  coalescing_store_buffer #(.ENTRIES(NE), .LINE_AW(LAW), .LINE_BYTES(LB)) u_coalescing_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line), .st_mask(st_mask), .st_data(st_data),
    .pf_valid(pf_valid), .pf_line(pf_line),
    .ld_line(ld_line), .ld_hit_mask(ld_hit_mask), .ld_data(ld_data),
    .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_line(drain_line),
    .drain_mask(drain_mask), .drain_data(drain_data), .drain_gid(drain_gid), .drain_last(drain_last)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Byte-wise expectation of two successive stores to one line
  function automatic logic [DW-1:0] two_store_bytes(input logic [LB-1:0] m1, input logic [DW-1:0] d1,
                                                    input logic [LB-1:0] m2, input logic [DW-1:0] d2);
    logic [DW-1:0] r = '0;
    for (int b = 0; b < LB; b++) begin
      if (m2[b])      r[b*8 +: 8] = d2[b*8 +: 8];
      else if (m1[b]) r[b*8 +: 8] = d1[b*8 +: 8];
    end
    return r;
  endfunction

  task automatic put(input logic [LAW-1:0] line, input logic [LB-1:0] m, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_line = line; st_mask = m; st_data = d;
    #1 check("R10 ready on store", 64'(st_ready), 64'd1);
    @(posedge clk);
    #1 st_valid = 1'b0;
    check("R9 prefetch valid", 64'(pf_valid), 64'd1);
    check("R9 prefetch line", 64'(pf_line), 64'(line));
  endtask

  task automatic probe_ready(input logic [LAW-1:0] line, input logic exp, input string req);
    @(negedge clk);
    st_valid = 1'b1; st_line = line; st_mask = '0;
    #1 check(req, 64'(st_ready), 64'(exp));
    st_valid = 1'b0;
  endtask

  task automatic take(output logic [LAW-1:0] line, output logic [LB-1:0] m, output logic [DW-1:0] d,
                      output logic [GW-1:0] g, output logic last);
    @(negedge clk);
    #1 check("R6 drain has a line", 64'(drain_valid), 64'd1);
    line = drain_line; m = drain_mask; d = drain_data; g = drain_gid; last = drain_last;
    drain_ready = 1'b1;
    @(posedge clk);
    #1 drain_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    #1 check(req, 64'(drain_valid), 64'd0);
  endtask

  task automatic look(input logic [LAW-1:0] line, input logic [LB-1:0] em, input logic [DW-1:0] ed, input string req);
    @(negedge clk);
    ld_line = line;
    #1 check({req, " hit mask"}, 64'(ld_hit_mask), 64'(em));
    check({req, " data"}, 64'(ld_data), 64'(ed));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [LAW-1:0] l;
    logic [LB-1:0]  m;
    logic [DW-1:0]  d;
    logic [GW-1:0]  g, g0, g1;
    logic           last;
    logic [7:0]     seen;
    int             gseq;

    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 ready after reset", 64'(st_ready), 64'd1);
    check("R12 no drain after reset", 64'(drain_valid), 64'd0);
    check("R12 no prefetch after reset", 64'(pf_valid), 64'd0);
    check("R12 lookup misses", 64'(ld_hit_mask), 64'd0);
    rst_n = 1'b1;

    // R1 / R11: lone stores get consecutive IDs from 0 and wrap modulo NE
    gseq = 0;
    for (int i = 0; i < 10; i++) begin
      put(LAW'(16 + i), 4'hF, 32'h1000_0000 + DW'(i) * 32'h0101_0101);
      take(l, m, d, g, last);
      check("R1 fresh id", 64'(g), 64'(gseq % NE));
      check("R6 drain line", 64'(l), 64'(16 + i));
      check("R6 drain data", 64'(d), 64'(32'h1000_0000 + i * 32'h0101_0101));
      check("R5 single line is last", 64'(last), 64'd1);
      expect_empty("R6 entry freed");
      gseq++;
    end

    // R2 / R8: every pair of byte masks merged into one line
    for (int m1 = 0; m1 < 16; m1++) begin
      for (int m2 = 0; m2 < 16; m2++) begin
        logic [DW-1:0] d1, d2, ex;
        d1 = 32'hA4A3_A2A1 ^ DW'(m2);
        d2 = 32'hB4B3_B2B1 ^ (DW'(m1) << 8);
        ex = two_store_bytes(LB'(m1), d1, LB'(m2), d2);
        put(8'd1, LB'(m1), d1);
        put(8'd1, LB'(m2), d2);
        look(8'd1, LB'(m1 | m2), ex, "R8 youngest bytes");
        take(l, m, d, g, last);
        check("R2 merged mask", 64'(m), 64'(m1 | m2));
        check("R2 merged data", 64'(d), 64'(ex));
        check("R2 one entry only", 64'(last), 64'd1);
        check("R11 id keeps cycling", 64'(g), 64'(gseq % NE));
        expect_empty("R2 no second entry");
        gseq++;
      end
    end

    // R3 / R10: D, A, B, C fill the buffer; a second store to A fuses A..C
    put(8'd40, 4'h1, 32'h0000_00D0);
    put(8'd41, 4'h1, 32'h0000_00A0);
    put(8'd42, 4'h1, 32'h0000_00B0);
    put(8'd43, 4'h1, 32'h0000_00C0);
    probe_ready(8'd44, 1'b0, "R10 stall when full and no match");
    probe_ready(8'd41, 1'b1, "R10 ready on open match when full");
    put(8'd41, 4'h2, 32'h0000_AB00);
    take(l, m, d, g0, last);
    check("R5 oldest group first", 64'(l), 64'd40);
    check("R5 oldest group one line", 64'(last), 64'd1);
    seen = '0;
    for (int k = 0; k < 3; k++) begin
      take(l, m, d, g, last);
      check("R3 merged group id", 64'(g), 64'(GW'(g0 + 1)));
      check("R5 last only at end", 64'(last), 64'(k == 2));
      if (l >= 8'd41 && l <= 8'd43) seen[l - 8'd41] = 1'b1;
      if (l == 8'd41) check("R2 merged into old A", 64'(d), 64'h0000_ABA0);
    end
    check("R3 all three lines drained", 64'(seen), 64'h7);
    expect_empty("R3 nothing left");

    // R4: A B A C B chains into one group
    put(8'd50, 4'h1, 32'h0000_0011);
    put(8'd51, 4'h1, 32'h0000_0022);
    put(8'd50, 4'h2, 32'h0000_3300);
    put(8'd52, 4'h1, 32'h0000_0044);
    put(8'd51, 4'h4, 32'h0055_0000);
    seen = '0;
    for (int k = 0; k < 3; k++) begin
      take(l, m, d, g, last);
      if (k == 0) g1 = g;
      check("R4 chained single id", 64'(g), 64'(g1));
      check("R4 last only at end", 64'(last), 64'(k == 2));
      if (l >= 8'd50 && l <= 8'd52) seen[l - 8'd50] = 1'b1;
      if (l == 8'd51) check("R4 chained merge data", 64'(d), 64'h0055_0022);
    end
    check("R4 three lines drained", 64'(seen), 64'h7);
    check("R11 next id after merge", 64'(g1), 64'(GW'(g0 + 2)));
    expect_empty("R4 nothing left");

    // R7: once a group begins writing out, its lines are closed
    put(8'd60, 4'hF, 32'h6666_6666);
    put(8'd61, 4'hF, 32'h7777_7777);
    put(8'd60, 4'h8, 32'h9900_0000);  // merge into open oldest group
    take(l, m, d, g0, last);
    check("R7 first of two lines not last", 64'(last), 64'd0);
    if (l == 8'd60) check("R2 merge into oldest before drain", 64'(d), 64'h9966_6666);
    // the line still waiting in the partly written group
    if (l == 8'd60) begin
      put(8'd61, 4'h1, 32'h0000_00EE);
      look(8'd61, 4'hF, 32'h7777_77EE, "R8 newer over closed");
      take(l, m, d, g, last);
      check("R7 closed line keeps old data", 64'(d), 64'h7777_7777);
      check("R7 closed line ends its group", 64'(last), 64'd1);
      check("R7 closed line keeps id", 64'(g), 64'(g0));
    end else begin
      put(8'd60, 4'h1, 32'h0000_00EE);
      look(8'd60, 4'hF, 32'h9966_66EE, "R8 newer over closed");
      take(l, m, d, g, last);
      check("R7 closed line keeps old data", 64'(d), 64'h9966_6666);
      check("R7 closed line ends its group", 64'(last), 64'd1);
      check("R7 closed line keeps id", 64'(g), 64'(g0));
    end
    take(l, m, d, g, last);
    check("R7 new entry new group", 64'(g), 64'(GW'(g0 + 1)));
    check("R7 new entry mask", 64'(m), 64'h1);
    check("R7 new entry data", 64'(d), 64'h0000_00EE);
    expect_empty("R7 nothing left");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule